// File: doc/BRIEF.md
# Partially Decoded Memory Slave

This block is a memory slave for an 8-bit processor bus with a 16-bit address. The two most significant address bits pick one of four regions of 16 KB each. The remaining bits give the byte offset inside the region. Each region is filled at compile time with one of three things: a read-only device, a read/write device, or nothing at all. Each device stores `2^DEV_AW` bytes, starting at the base of its region.

By default every address bit takes part in decoding. A device then answers only at the low offsets of its own region, and every other address reads as a hole. The `IGNORE_MASK` parameter takes chosen address bits out of decoding. Any location behind those bits then answers at every combination of them, so a device repeats across the space at aliased addresses.

Elaboration stops with an error in either of two cases:
- Two populated regions would answer the same address.
- The device is not smaller than a region.

The host controls the block with three active-low strobes: a memory request, a read and a write. Writes are synchronous. Read data is combinational.

Top module: `partial_decode_mem`

## Requirements
- R1: The region is selected by address bits 15:14. The default map is: region 0 read-only, region 1 empty, regions 2 and 3 read/write. A device answers only when offset bits 13..DEV_AW (13..8 by default) are zero or ignored. The device byte index is address bits DEV_AW-1:0.
- R2: `rdata_o` is FFh whenever `mreq_ni` or `rd_ni` is high. Nothing is stored unless `mreq_ni` and `wr_ni` are both low.
- R3: A read from an empty region, or from a hole inside a region, returns FFh. A write there changes no stored byte.
- R4: The read-only byte at index k is (5Ah + 3*k) mod 256. Writes to it leave that value unchanged.
- R5: A read/write device stores `wdata_i` on the rising clock edge at which `mreq_ni` and `wr_ni` are both low. The stored value is visible combinationally on the next read of that address.
- R6: `rst_ni` low clears every read/write byte to 00h.
- R7: Address bits set in `IGNORE_MASK` do not take part in decoding. A write through one alias therefore reads back through any other alias of the same location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes are captured on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write data |
| mreq_ni | input | 1 | Active-low memory request |
| rd_ni | input | 1 | Active-low read strobe |
| wr_ni | input | 1 | Active-low write strobe |
| rdata_o | output | 8 | Read data; FFh when no device is read |

## Verification
The assertions assume that the bus inputs change only away from the rising clock edge. The write-readback property also assumes that the address is stable for the whole cycle in which a strobe is low. The bench meets both assumptions by driving every input on the falling edge and holding it until the next falling edge.

The bench uses two configurations, both driven from the same bus:
- Full decoding.
- A configuration that ignores bit 15 and bits 13..8.

It writes every address in the 64 KB space back to back, then reads every address back. The bench keeps its own model of which stored cell each alias reaches.

// File: rtl/mem_pkg.sv
package mem_pkg;
  localparam logic [1:0] KIND_EMPTY = 2'd0;
  localparam logic [1:0] KIND_ROM   = 2'd1;
  localparam logic [1:0] KIND_RAM   = 2'd2;
endpackage

// File: rtl/mem_region_decode.sv
module mem_region_decode #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned MID_W  = 6,
  parameter int unsigned REGION = 0,
  parameter logic [SEL_W-1:0] IGN_SEL = '0,
  parameter logic [MID_W-1:0] IGN_MID = '0
) (
  input  logic             req_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [MID_W-1:0] mid_i,
  output logic             hit_o
);
  localparam logic [SEL_W-1:0] BASE = SEL_W'(REGION);

  logic sel_match, mid_clear;
  assign sel_match = ((sel_i ^ BASE) & ~IGN_SEL) == '0;
  assign mid_clear = (mid_i & ~IGN_MID) == '0;
  assign hit_o     = req_i & sel_match & mid_clear;
endmodule

// File: rtl/mem_ram_bank.sv
module mem_ram_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mem_rom_bank.sv
module mem_rom_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 8,
  parameter int unsigned SEED   = 32'h5A,
  parameter int unsigned STEP   = 3
) (
  input  logic [AW-1:0]     addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  // contents are a function of the index, no table needed
  assign rdata_o = DATA_W'(SEED + STEP * 32'(addr_i));
endmodule

// File: rtl/partial_decode_mem.sv
module partial_decode_mem #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DEV_AW = 8,
  parameter logic [ADDR_W-1:0] IGNORE_MASK = '0,
  parameter logic [2*(1<<SEL_W)-1:0] REGION_MAP = 8'hA1,
  parameter int unsigned ROM_SEED = 32'h5A,
  parameter int unsigned ROM_STEP = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mreq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic [DATA_W-1:0] rdata_o
);
  import mem_pkg::*;

  localparam int unsigned NUM_REGIONS = 1 << SEL_W;
  localparam int unsigned OFFSET_W    = ADDR_W - SEL_W;
  localparam int unsigned MID_W       = OFFSET_W - DEV_AW;
  localparam logic [SEL_W-1:0] IGN_SEL = IGNORE_MASK[ADDR_W-1:OFFSET_W];
  localparam logic [MID_W-1:0] IGN_MID = IGNORE_MASK[OFFSET_W-1:DEV_AW];

  if (DEV_AW >= OFFSET_W) begin : g_bad_size
    $error("device must be smaller than a region");
  end

  // reject maps where ignored select bits fold two populated regions together
  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_ov_i
    for (genvar j = i + 1; j < NUM_REGIONS; j++) begin : g_ov_j
      localparam logic [SEL_W-1:0] DIFF = SEL_W'(i ^ j);
      if (REGION_MAP[2*i +: 2] != KIND_EMPTY && REGION_MAP[2*j +: 2] != KIND_EMPTY
          && ((DIFF & ~IGN_SEL) == '0)) begin : g_overlap
        $error("populated regions overlap under IGNORE_MASK");
      end
    end
  end

  logic              req, rd_en, wr_en;
  logic [SEL_W-1:0]  sel;
  logic [MID_W-1:0]  mid;
  logic [DEV_AW-1:0] idx;
  logic [NUM_REGIONS-1:0] hit_vec;
  logic [DATA_W-1:0] dev_data [NUM_REGIONS];

  assign req   = ~mreq_ni;
  assign rd_en = req & ~rd_ni;
  assign wr_en = req & ~wr_ni;
  assign sel   = addr_i[ADDR_W-1:OFFSET_W];
  assign mid   = addr_i[OFFSET_W-1:DEV_AW];
  assign idx   = addr_i[DEV_AW-1:0];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    localparam logic [1:0] KIND = REGION_MAP[2*r +: 2];
    if (KIND == KIND_EMPTY) begin : g_empty
      assign hit_vec[r]  = 1'b0;
      assign dev_data[r] = '1;
    end else begin : g_dev
      mem_region_decode #(
        .SEL_W(SEL_W), .MID_W(MID_W), .REGION(r),
        .IGN_SEL(IGN_SEL), .IGN_MID(IGN_MID)
      ) u_dec (
        .req_i(req), .sel_i(sel), .mid_i(mid), .hit_o(hit_vec[r])
      );
      if (KIND == KIND_ROM) begin : g_rom
        mem_rom_bank #(
          .DATA_W(DATA_W), .AW(DEV_AW), .SEED(ROM_SEED), .STEP(ROM_STEP)
        ) u_rom (
          .addr_i(idx), .rdata_o(dev_data[r])
        );
      end else begin : g_ram
        mem_ram_bank #(.DATA_W(DATA_W), .AW(DEV_AW)) u_ram (
          .clk_i(clk_i), .rst_ni(rst_ni), .we_i(hit_vec[r] & wr_en),
          .addr_i(idx), .wdata_i(wdata_i), .rdata_o(dev_data[r])
        );
      end
    end
  end

  always_comb begin
    rdata_o = '1;
    if (rd_en) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (hit_vec[r]) rdata_o = dev_data[r];
      end
    end
  end
endmodule

// File: rtl/mem_checker.sv
module mem_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DEV_AW = 8,
  parameter logic [ADDR_W-1:0] IGNORE_MASK = '0,
  parameter logic [2*(1<<SEL_W)-1:0] REGION_MAP = 8'hA1,
  parameter int unsigned ROM_SEED = 32'h5A,
  parameter int unsigned ROM_STEP = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              mreq_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned OFFSET_W = ADDR_W - SEL_W;

  logic rd_act, wr_act, mid_clear;
  logic [SEL_W-1:0] sel;
  logic [1:0] kind;
  logic [DATA_W-1:0] rom_val;

  assign rd_act    = !mreq_ni && !rd_ni;
  assign wr_act    = !mreq_ni && !wr_ni;
  assign sel       = addr_i[ADDR_W-1:OFFSET_W];
  assign kind      = REGION_MAP[2*sel +: 2];
  assign mid_clear = (addr_i[OFFSET_W-1:DEV_AW] & ~IGNORE_MASK[OFFSET_W-1:DEV_AW]) == '0;
  assign rom_val   = DATA_W'(ROM_SEED + ROM_STEP * 32'(addr_i[DEV_AW-1:0]));

  // R2: no strobe, no data
  a_r2_idle_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_act |-> rdata_o == '1);

  // R3: holes inside a region float high
  a_r3_gap_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && !mid_clear) |-> rdata_o == '1);

  // R4: read-only contents never change, whatever was written
  a_r4_rom_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && mid_clear && kind == mem_pkg::KIND_ROM) |-> rdata_o == rom_val);

  // R5: a stored byte is visible on the following read of the same address
  a_r5_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_act && mid_clear && kind == mem_pkg::KIND_RAM) && rd_act
     && addr_i == $past(addr_i)) |-> rdata_o == $past(wdata_i));
endmodule

bind partial_decode_mem mem_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .DEV_AW(DEV_AW),
  .IGNORE_MASK(IGNORE_MASK), .REGION_MAP(REGION_MAP),
  .ROM_SEED(ROM_SEED), .ROM_STEP(ROM_STEP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .mreq_ni(mreq_ni), .rd_ni(rd_ni), .wr_ni(wr_ni), .rdata_o(rdata_o)
);

// File: tb/tb_partial_decode_mem.sv
module tb_partial_decode_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  rdata_f, rdata_a;

  int checks = 0;
  int fails  = 0;

  logic [7:0] ram_f [2][256];
  logic [7:0] ram_a [256];

  always #4 clk = ~clk;  // 125 MHz

  partial_decode_mem dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .mreq_ni(mreq_n), .rd_ni(rd_n), .wr_ni(wr_n), .rdata_o(rdata_f)
  );

  // bit 15 and bits 13..8 ignored; region 0 read-only, region 1 read/write
  partial_decode_mem #(.IGNORE_MASK(16'hBF00), .REGION_MAP(8'h09)) dut_alias (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .mreq_ni(mreq_n), .rd_ni(rd_n), .wr_ni(wr_n), .rdata_o(rdata_a)
  );

  function automatic logic [7:0] rom_b(logic [7:0] k);
    return 8'(8'h5A + 3 * int'(k));
  endfunction

  function automatic logic [7:0] exp_full(logic [15:0] a);
    if (a[13:8] != 0) return 8'hFF;
    case (a[15:14])
      2'd0:    return rom_b(a[7:0]);
      2'd1:    return 8'hFF;
      default: return ram_f[a[14]][a[7:0]];
    endcase
  endfunction

  function automatic logic [7:0] exp_alias(logic [15:0] a);
    return a[14] ? ram_a[a[7:0]] : rom_b(a[7:0]);
  endfunction

  function automatic string tag_full(logic [15:0] a);
    if (a[13:8] != 0 || a[15:14] == 2'd1) return "R3";
    if (a[15:14] == 2'd0) return "R4";
    return "R1";
  endfunction

  task automatic check(string tag, logic [15:0] a, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, got, exp);
    end
  endtask

  // one write per cycle; strobes stay low until the caller idles the bus
  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; mreq_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
    if (a[15] && a[13:8] == 0) ram_f[a[14]][a[7:0]] = d;
    if (a[14]) ram_a[a[7:0]] = d;
  endtask

  task automatic bus_idle();
    @(negedge clk);
    mreq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic read_both(logic [15:0] a, string tf, string ta);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    #2;
    check(tf, a, rdata_f, exp_full(a));
    check(ta, a, rdata_a, exp_alias(a));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram_f[0][i] = '0; ram_f[1][i] = '0; ram_a[i] = '0;
    end
    repeat (3) @(posedge clk);
    #2;
    check("R2", addr, rdata_f, 8'hFF);  // idle bus during reset
    @(negedge clk);
    rst_n = 1'b1;

    // R6: cleared after reset
    read_both(16'h8000, "R6", "R6");
    read_both(16'hC0FF, "R6", "R6");
    read_both(16'h4055, "R6", "R6");

    // R2: a missing strobe yields FFh
    @(negedge clk);
    addr = 16'h0001; mreq_n = 1'b1; rd_n = 1'b0; #2;
    check("R2", addr, rdata_f, 8'hFF);
    @(negedge clk);
    mreq_n = 1'b0; rd_n = 1'b1; #2;
    check("R2", addr, rdata_f, 8'hFF);

    // R2: write without request stores nothing
    @(negedge clk);
    addr = 16'h8005; wdata = 8'h77; mreq_n = 1'b1; wr_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b1;
    read_both(16'h8005, "R2", "R2");

    // R4: write into the read-only region is dropped
    bus_write(16'h0003, 8'h00);
    bus_idle();
    read_both(16'h0003, "R4", "R4");
    check("R4", 16'h0003, rdata_f, 8'h63);

    // R3: write into the empty region is dropped
    bus_write(16'h4010, 8'h12);
    bus_idle();
    read_both(16'h4010, "R3", "R7");

    // R5: write then read back in the next cycle
    bus_write(16'hC0FE, 8'h5D);
    read_both(16'hC0FE, "R5", "R7");
    check("R5", 16'hC0FE, rdata_f, 8'h5D);

    // R7: write through one alias, read through others
    bus_write(16'h4012, 8'hAB);
    read_both(16'hFF12, "R3", "R7");
    check("R7", 16'hFF12, rdata_a, 8'hAB);
    read_both(16'h7E12, "R3", "R7");
    read_both(16'h8007, "R1", "R7");
    check("R7", 16'h8007, rdata_a, rom_b(8'h07));

    // full sweep: write every address, then read every address
    for (int a = 0; a < 65536; a++) begin
      bus_write(16'(a), 8'(a) ^ 8'(a >> 8) ^ 8'hC3);
    end
    bus_idle();
    for (int a = 0; a < 65536; a++) begin
      read_both(16'(a), tag_full(16'(a)), "R7");
    end
    bus_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule